// File: doc/BRIEF.md
# I2C Slave Address Comparator

This block decides whether a byte that a slave interface has just received addresses this device. It looks only at the first byte after a START condition. It compares that byte with a programmed own-address register, in either 7-bit or 10-bit addressing mode. It also recognises the general call address. From the R/W bit it derives a pulse that sets or clears the transfer-direction flag held by the surrounding controller.

A shift stage upstream delivers each received byte with a one-cycle strobe, and a flag tells whether the byte is the first one since START. The block answers one cycle later with single-cycle pulses: match, general call, direction set, direction clear and byte-complete interrupt.

A free-data control input turns address recognition off. When it is high, every first byte raises the interrupt and the direction flag is left untouched. The second byte of a 10-bit address and all bus-level sampling are handled elsewhere.

Top module: `i2c_addr_cmp`

## Requirements
- R1: After reset is asserted (rst_ni low), all five outputs are 0.
- R2: A byte strobe with first_byte_i = 0 produces no output pulse; only the first byte after START is evaluated.
- R3: With mode_10b_i = 0, received bits [7:1] are compared with own_addr_i[7:1]; bit 0 (the R/W bit) does not affect the match.
- R4: With mode_10b_i = 1, all 8 received bits are compared with all 8 bits of own_addr_i, so a difference in bit 0 gives no match.
- R5: A received first byte equal to 8'h00 raises gcall_o and also raises match_o, whatever own_addr_i holds.
- R6: Each output pulse is high for exactly the one clock cycle that follows the clock edge sampling the strobe.
- R7: With free_data_i = 0 and a match, R/W bit (bit 0) = 1 raises trx_set_o and R/W = 0 raises trx_clr_o; with no match, neither pulse occurs.
- R8: With free_data_i = 1, neither trx_set_o nor trx_clr_o ever pulses.
- R9: irq_o pulses with free_data_i = 0 only on a match (including general call); with free_data_i = 1 it pulses on every evaluated first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_vld_i | input | 1 | One-cycle strobe: rx_byte_i holds a complete byte |
| first_byte_i | input | 1 | Byte is the first one after a START condition |
| rx_byte_i | input | 8 | Received byte, R/W in bit 0 |
| own_addr_i | input | 8 | Programmed own-address register |
| mode_10b_i | input | 1 | 1: 10-bit addressing first-byte compare, 0: 7-bit |
| free_data_i | input | 1 | 1: free-data mode, no address recognition |
| match_o | output | 1 | Address matched (pulse) |
| gcall_o | output | 1 | General call received (pulse) |
| trx_set_o | output | 1 | Set transfer direction to transmit (pulse) |
| trx_clr_o | output | 1 | Clear transfer direction to receive (pulse) |
| irq_o | output | 1 | Byte-complete interrupt after address reception (pulse) |

## Verification
The bench builds the block with its defaults: an 8-bit address byte and general call detection enabled through the GCALL_EN generate branch. These settings reach every path in the requirements. In 7-bit mode the bench checks that the R/W bit is ignored in the compare, and in 10-bit mode that a one-bit difference in bit 0 breaks the match. It also covers the all-zero general call against a nonzero own address, and free-data mode, where the interrupt fires on a mismatch but no direction pulse appears. A byte strobed without the first-byte flag must produce nothing. Each pulse is checked in the cycle after its strobe, and again one cycle later to confirm it has dropped.

// File: rtl/i2c_acmp_pkg.sv
package i2c_acmp_pkg;
  typedef struct packed {
    logic match;
    logic gcall;
    logic trx_set;
    logic trx_clr;
    logic irq;
  } acmp_evt_t;
endpackage

// File: rtl/i2c_acmp_match.sv
module i2c_acmp_match #(
  parameter int unsigned ADDR_BITS = 8,
  parameter bit          GCALL_EN  = 1'b1
) (
  input  logic [ADDR_BITS-1:0] rx_i,
  input  logic [ADDR_BITS-1:0] own_i,
  input  logic                 mode_10b_i,
  output logic                 hit_o,
  output logic                 gcall_o
);
  localparam int unsigned SLV_W = ADDR_BITS - 1;

  logic hit_7b, hit_10b;
  assign hit_7b  = (rx_i[ADDR_BITS-1 -: SLV_W] == own_i[ADDR_BITS-1 -: SLV_W]);
  assign hit_10b = (rx_i == own_i);

  generate
    if (GCALL_EN) begin : g_gcall
      assign gcall_o = (rx_i == '0);
    end else begin : g_no_gcall
      assign gcall_o = 1'b0;
    end
  endgenerate

  assign hit_o = gcall_o | (mode_10b_i ? hit_10b : hit_7b);
endmodule

// File: rtl/i2c_acmp_resp.sv
module i2c_acmp_resp
  import i2c_acmp_pkg::*;
(
  input  logic      eval_i,
  input  logic      hit_i,
  input  logic      gcall_i,
  input  logic      rw_i,
  input  logic      free_data_i,
  output acmp_evt_t evt_o
);
  logic addressed;
  assign addressed = eval_i & ~free_data_i & hit_i;

  always_comb begin
    evt_o         = '0;
    evt_o.match   = eval_i & hit_i;
    evt_o.gcall   = eval_i & gcall_i;
    evt_o.trx_set = addressed &  rw_i;
    evt_o.trx_clr = addressed & ~rw_i;
    // free-data mode interrupts on any address byte
    evt_o.irq     = eval_i & (free_data_i | hit_i);
  end
endmodule

// File: rtl/i2c_addr_cmp.sv
module i2c_addr_cmp
  import i2c_acmp_pkg::*;
#(
  parameter int unsigned ADDR_BITS = 8,
  parameter bit          GCALL_EN  = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 byte_vld_i,
  input  logic                 first_byte_i,
  input  logic [ADDR_BITS-1:0] rx_byte_i,
  input  logic [ADDR_BITS-1:0] own_addr_i,
  input  logic                 mode_10b_i,
  input  logic                 free_data_i,
  output logic                 match_o,
  output logic                 gcall_o,
  output logic                 trx_set_o,
  output logic                 trx_clr_o,
  output logic                 irq_o
);
  logic      hit, gcall, eval;
  acmp_evt_t evt_d, evt_q;

  assign eval = byte_vld_i & first_byte_i;

  i2c_acmp_match #(
    .ADDR_BITS (ADDR_BITS),
    .GCALL_EN  (GCALL_EN)
  ) u_match (
    .rx_i       (rx_byte_i),
    .own_i      (own_addr_i),
    .mode_10b_i (mode_10b_i),
    .hit_o      (hit),
    .gcall_o    (gcall)
  );

  i2c_acmp_resp u_resp (
    .eval_i      (eval),
    .hit_i       (hit),
    .gcall_i     (gcall),
    .rw_i        (rx_byte_i[0]),
    .free_data_i (free_data_i),
    .evt_o       (evt_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= evt_d;
  end

  assign match_o   = evt_q.match;
  assign gcall_o   = evt_q.gcall;
  assign trx_set_o = evt_q.trx_set;
  assign trx_clr_o = evt_q.trx_clr;
  assign irq_o     = evt_q.irq;
endmodule

// File: rtl/i2c_addr_cmp_chk.sv
module i2c_addr_cmp_chk #(
  parameter int unsigned ADDR_BITS = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 byte_vld_i,
  input logic                 first_byte_i,
  input logic [ADDR_BITS-1:0] rx_byte_i,
  input logic                 free_data_i,
  input logic                 match_o,
  input logic                 gcall_o,
  input logic                 trx_set_o,
  input logic                 trx_clr_o,
  input logic                 irq_o
);
  AST_PULSE_NEEDS_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o || irq_o) |-> $past(byte_vld_i && first_byte_i)); // R2
  AST_GCALL_IS_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gcall_o |-> match_o); // R5
  AST_GCALL_ZERO_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gcall_o |-> ($past(rx_byte_i) == '0)); // R5
  AST_TRX_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(trx_set_o && trx_clr_o)); // R7
  AST_TRX_DIR_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trx_set_o |-> $past(rx_byte_i[0])); // R7
  AST_TRX_NO_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trx_set_o || trx_clr_o) |-> (!$past(free_data_i) && match_o)); // R8
  AST_IRQ_ADDRESSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !$past(free_data_i)) |-> match_o); // R9
endmodule

bind i2c_addr_cmp i2c_addr_cmp_chk #(.ADDR_BITS(ADDR_BITS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .byte_vld_i   (byte_vld_i),
  .first_byte_i (first_byte_i),
  .rx_byte_i    (rx_byte_i),
  .free_data_i  (free_data_i),
  .match_o      (match_o),
  .gcall_o      (gcall_o),
  .trx_set_o    (trx_set_o),
  .trx_clr_o    (trx_clr_o),
  .irq_o        (irq_o)
);

// File: tb/tb_i2c_addr_cmp.sv
module tb_i2c_addr_cmp;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       byte_vld_i = 1'b0;
  logic       first_byte_i = 1'b0;
  logic [7:0] rx_byte_i = '0;
  logic [7:0] own_addr_i = '0;
  logic       mode_10b_i = 1'b0;
  logic       free_data_i = 1'b0;
  logic       match_o, gcall_o, trx_set_o, trx_clr_o, irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  i2c_addr_cmp dut (.*);

  // outputs packed {match, gcall, set, clr, irq}
  task automatic check(input string req, input logic [4:0] exp);
    logic [4:0] act;
    act = {match_o, gcall_o, trx_set_o, trx_clr_o, irq_o};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs act=%b exp=%b", req, act, exp);
    end
  endtask

  // drive at negedge, registered at next posedge, sample the negedge after
  task automatic send(input string req, input logic [7:0] b, input logic first,
                      input logic [7:0] own, input logic m10, input logic als,
                      input logic [4:0] exp);
    @(negedge clk_i);
    rx_byte_i = b; first_byte_i = first; own_addr_i = own;
    mode_10b_i = m10; free_data_i = als; byte_vld_i = 1'b1;
    @(negedge clk_i);
    byte_vld_i = 1'b0; first_byte_i = 1'b0;
    check(req, exp);
    @(negedge clk_i);
    check({req, " R6 drop"}, 5'b0);
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    check("R1", 5'b0);
    rst_ni = 1'b1;
  endtask

  task automatic t_not_first;
    send("R2", 8'hA4, 1'b0, 8'hA4, 1'b0, 1'b0, 5'b0);
    send("R2 gc", 8'h00, 1'b0, 8'h10, 1'b0, 1'b1, 5'b0);
  endtask

  task automatic t_7bit;
    send("R3 rw0", 8'hA4, 1'b1, 8'hA5, 1'b0, 1'b0, 5'b10011);
    send("R3 rw1", 8'hA5, 1'b1, 8'hA4, 1'b0, 1'b0, 5'b10101);
    send("R3 miss", 8'hA6, 1'b1, 8'hA4, 1'b0, 1'b0, 5'b0);
  endtask

  task automatic t_10bit;
    send("R4 hit", 8'hF3, 1'b1, 8'hF3, 1'b1, 1'b0, 5'b10101);
    send("R4 lsb", 8'hF2, 1'b1, 8'hF3, 1'b1, 1'b0, 5'b0);
    send("R4 msb", 8'h73, 1'b1, 8'hF3, 1'b1, 1'b0, 5'b0);
  endtask

  task automatic t_gcall;
    send("R5 7b", 8'h00, 1'b1, 8'h5A, 1'b0, 1'b0, 5'b11011);
    send("R5 10b", 8'h00, 1'b1, 8'hF1, 1'b1, 1'b0, 5'b11011);
  endtask

  task automatic t_free;
    send("R8 R9 miss", 8'h33, 1'b1, 8'hA4, 1'b0, 1'b1, 5'b00001);
    send("R8 hit", 8'hA5, 1'b1, 8'hA4, 1'b0, 1'b1, 5'b10001);
  endtask

  task automatic t_back_to_back;
    @(negedge clk_i);
    rx_byte_i = 8'h21; first_byte_i = 1'b1; own_addr_i = 8'h20;
    mode_10b_i = 1'b0; free_data_i = 1'b0; byte_vld_i = 1'b1;
    @(negedge clk_i);
    check("R6 R7 first", 5'b10101);
    rx_byte_i = 8'h44;
    @(negedge clk_i);
    byte_vld_i = 1'b0; first_byte_i = 1'b0;
    check("R6 R9 second", 5'b0);
  endtask

  initial begin : watchdog
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_not_first();
    t_7bit();
    t_10bit();
    t_gcall();
    t_free();
    t_back_to_back();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule